// File: doc/BRIEF.md
# Standby Mode Controller with Interrupt Gating

This block decides when a small processor core enters and leaves its low-power states. The core writes a control byte that holds a stop request and a sleep request. The controller moves to sleep, to stop, or stays active. Sleep turns off only the core clock enable. Stop turns off both the core clock enable and the peripheral clock enable.

Entry is refused while any peripheral holds a pending request at a level that is not the disabled level 11B. The refusal does not depend on the core's enable flag or its current level. In either low-power state, such a request brings the controller back to active at once, again whatever the core's acceptance state is. On that return the block issues a one-cycle wake pulse. Together with the pulse it gives a take-interrupt decision, which tells the core whether to branch to the handler or to continue with the next instruction.

Interrupt detection is purely combinational on the request and level inputs. Because of this, wake-up works even when every clock enable is off.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the mode output is 00 (active), the control readback is 0x00, both clock enables are 1, and wake and take-interrupt are 0.
- R2: A write with bit 6 set and bit 7 clear, made while active and with no qualifying request, gives mode 01 (sleep) from the next cycle. The readback is then 0x40, the core clock enable is 0 and the peripheral clock enable stays 1.
- R3: A write with bit 7 set, made while active and with no qualifying request, gives mode 10 (stop) from the next cycle. The readback is then 0x80 and both clock enables are 0.
- R4: A write with both bit 7 and bit 6 set enters stop (mode 10), not sleep.
- R5: A source qualifies when its request flag is 1 and its 2-bit level, held in level bits [2i+1:2i] for source i, is not 11. While any source qualifies, a write of the stop or sleep bit leaves the mode at 00. This holds for every value of the core's enable flag and level.
- R6: A source whose level is 11 neither blocks entry nor wakes the controller from standby.
- R7: In sleep or stop, a qualifying request returns the mode to 00 on the next clock edge. On that same edge wake rises for exactly one cycle and the readback becomes 0x00.
- R8: Take-interrupt is 1 only in the wake cycle, and only if the core enable flag was 1 and the smallest qualifying level was strictly less than the core level, both sampled on the waking edge. Otherwise it is 0.
- R9: Writes made while in sleep or stop do not change the mode.
- R10: Writing 0x00 while active leaves the mode at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: bit 7 stop, bit 6 sleep |
| rd_data | output | 8 | Control byte readback |
| irq_req | input | N_SRC | Per-source request flags |
| irq_lvl | input | 2*N_SRC | Per-source levels, source i at [2i+1:2i] |
| cpu_ie | input | 1 | Core interrupt-enable flag |
| cpu_lvl | input | 2 | Core current level |
| mode | output | 2 | 00 active, 01 sleep, 10 stop |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake | output | 1 | One-cycle pulse on leaving standby |
| take_irq | output | 1 | Branch-to-handler decision, valid with wake |

## Verification
The hardest case to reach is a wake-up in which the vectoring decision depends on which of several simultaneous requests holds the smallest level, or in which a disabled-level source is active at the same time. The stimulus table covers these cases. Each row first enters a chosen standby state with all requests low. The row then raises a multi-source request pattern together with a chosen core enable and level in a single cycle. This means the decision is sampled on exactly the waking edge. Directed steps then hold a qualifying request across an entry write, and write to the control byte while in standby.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [1:0] {
      MODE_ACT = 2'b00,
      MODE_SLP = 2'b01,
      MODE_STP = 2'b10
   } mode_e;

   localparam int unsigned LVL_W = 2;
   localparam logic [LVL_W-1:0] LVL_OFF = 2'b11;
endpackage

// File: rtl/stby_irq_eval.sv
module stby_irq_eval
   import stby_pkg::*;
#(
   parameter int unsigned N_SRC = 4
) (
   input  logic [N_SRC-1:0]       irq_req,
   input  logic [N_SRC*LVL_W-1:0] irq_lvl,
   output logic                   any_pend,
   output logic [LVL_W-1:0]       best_lvl
);
   logic [N_SRC-1:0] qual;

   for (genvar i = 0; i < N_SRC; i++) begin : g_qual
      assign qual[i] = irq_req[i] && (irq_lvl[i*LVL_W +: LVL_W] != LVL_OFF);
   end

   assign any_pend = |qual;

   always_comb begin
      best_lvl = LVL_OFF;
      for (int i = 0; i < N_SRC; i++) begin
         if (qual[i] && (irq_lvl[i*LVL_W +: LVL_W] < best_lvl))
            best_lvl = irq_lvl[i*LVL_W +: LVL_W];
      end
   end
endmodule

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
   import stby_pkg::*;
#(
   parameter int unsigned REG_W     = 8,
   parameter int unsigned STOP_BIT  = 7,
   parameter int unsigned SLEEP_BIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             any_pend,
   input  logic [LVL_W-1:0] best_lvl,
   input  logic             cpu_ie,
   input  logic [LVL_W-1:0] cpu_lvl,
   output mode_e            mode_q,
   output logic             wake_q,
   output logic             take_q
);
   mode_e mode_d;
   logic  leave;

   assign leave = (mode_q != MODE_ACT) && any_pend;

   always_comb begin
      mode_d = mode_q;
      if (mode_q == MODE_ACT) begin
         if (wr_en && !any_pend) begin
            if (wr_data[STOP_BIT])
               mode_d = MODE_STP;
            else if (wr_data[SLEEP_BIT])
               mode_d = MODE_SLP;
         end
      end else if (leave) begin
         mode_d = MODE_ACT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ACT;
         wake_q <= 1'b0;
         take_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         wake_q <= leave;
         take_q <= leave && cpu_ie && (best_lvl < cpu_lvl);
      end
   end
endmodule

// File: rtl/stby_gate.sv
module stby_gate
   import stby_pkg::*;
#(
   parameter int unsigned REG_W     = 8,
   parameter int unsigned STOP_BIT  = 7,
   parameter int unsigned SLEEP_BIT = 6
) (
   input  mode_e            mode_q,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic [REG_W-1:0] rd_data
);
   always_comb begin
      rd_data            = '0;
      rd_data[STOP_BIT]  = (mode_q == MODE_STP);
      rd_data[SLEEP_BIT] = (mode_q == MODE_SLP);
   end

   assign cpu_clk_en = (mode_q == MODE_ACT);
   assign per_clk_en = (mode_q != MODE_STP);
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
   import stby_pkg::*;
#(
   parameter int unsigned N_SRC     = 4,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned STOP_BIT  = 7,
   parameter int unsigned SLEEP_BIT = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [REG_W-1:0]       wr_data,
   output logic [REG_W-1:0]       rd_data,
   input  logic [N_SRC-1:0]       irq_req,
   input  logic [N_SRC*LVL_W-1:0] irq_lvl,
   input  logic                   cpu_ie,
   input  logic [LVL_W-1:0]       cpu_lvl,
   output logic [1:0]             mode,
   output logic                   cpu_clk_en,
   output logic                   per_clk_en,
   output logic                   wake,
   output logic                   take_irq
);
   if (N_SRC < 1) begin : g_bad_nsrc
      $error("stby_ctrl: N_SRC must be at least 1");
   end
   if (STOP_BIT >= REG_W || SLEEP_BIT >= REG_W || STOP_BIT == SLEEP_BIT) begin : g_bad_bits
      $error("stby_ctrl: control bit positions invalid");
   end

   logic             any_pend;
   logic [LVL_W-1:0] best_lvl;
   mode_e            mode_q;

   stby_irq_eval #(.N_SRC(N_SRC)) u_eval (
      .irq_req  (irq_req),
      .irq_lvl  (irq_lvl),
      .any_pend (any_pend),
      .best_lvl (best_lvl)
   );

   stby_mode_fsm #(.REG_W(REG_W), .STOP_BIT(STOP_BIT), .SLEEP_BIT(SLEEP_BIT)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .any_pend (any_pend),
      .best_lvl (best_lvl),
      .cpu_ie   (cpu_ie),
      .cpu_lvl  (cpu_lvl),
      .mode_q   (mode_q),
      .wake_q   (wake),
      .take_q   (take_irq)
   );

   stby_gate #(.REG_W(REG_W), .STOP_BIT(STOP_BIT), .SLEEP_BIT(SLEEP_BIT)) u_gate (
      .mode_q     (mode_q),
      .cpu_clk_en (cpu_clk_en),
      .per_clk_en (per_clk_en),
      .rd_data    (rd_data)
   );

   assign mode = mode_q;
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
   parameter int unsigned N_SRC    = 4,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned STOP_BIT = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [REG_W-1:0]     wr_data,
   input logic [N_SRC-1:0]     irq_req,
   input logic [N_SRC*2-1:0]   irq_lvl,
   input logic [1:0]           mode,
   input logic                 wake,
   input logic                 take_irq
);
   logic pend;
   always_comb begin
      pend = 1'b0;
      for (int i = 0; i < N_SRC; i++)
         pend = pend | (irq_req[i] && (irq_lvl[2*i +: 2] != 2'b11));
   end

   // R5
   a_r5_refuse_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pend && mode == 2'b00) |=> mode == 2'b00);
   // R3, R4
   a_r3_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pend && mode == 2'b00 && wr_data[STOP_BIT]) |=> mode == 2'b10);
   // R7
   a_r7_wake_return: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b00 && pend) |=> (wake && mode == 2'b00));
   a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);
   // R8
   a_r8_take_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> wake);
   // R6, R9
   a_r9_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b00 && !pend) |=> $stable(mode));
endmodule

bind stby_ctrl stby_ctrl_chk #(.N_SRC(N_SRC), .REG_W(REG_W), .STOP_BIT(STOP_BIT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .irq_req  (irq_req),
   .irq_lvl  (irq_lvl),
   .mode     (mode),
   .wake     (wake),
   .take_irq (take_irq)
);

// File: tb/sim_stby_ctrl.sv
module sim_stby_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [3:0] irq_req = '0;
   logic [7:0] irq_lvl = '0;
   logic       cpu_ie = 1'b0;
   logic [1:0] cpu_lvl = 2'b00;
   logic [1:0] mode;
   logic       cpu_clk_en, per_clk_en, wake, take_irq;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   stby_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .irq_req(irq_req), .irq_lvl(irq_lvl), .cpu_ie(cpu_ie), .cpu_lvl(cpu_lvl),
      .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .wake(wake), .take_irq(take_irq)
   );

   typedef struct packed {
      logic [7:0] wd;
      logic [3:0] req;
      logic [7:0] lvl;
      logic       ie;
      logic [1:0] cl;
      logic [1:0] xmode;
      logic       xtake;
   } vec_t;

   // R2 R3 R4 R7 R8
   localparam vec_t VECS [6] = '{
      '{8'h40, 4'b0001, 8'b11_11_11_00, 1'b1, 2'b10, 2'b01, 1'b1},
      '{8'h80, 4'b0010, 8'b11_11_01_11, 1'b0, 2'b11, 2'b10, 1'b0},
      '{8'hC0, 4'b0100, 8'b11_10_11_11, 1'b1, 2'b10, 2'b10, 1'b0},
      '{8'h40, 4'b1000, 8'b01_11_11_11, 1'b1, 2'b11, 2'b01, 1'b1},
      '{8'h80, 4'b0011, 8'b11_11_00_10, 1'b1, 2'b01, 2'b10, 1'b1},
      '{8'h40, 4'b0101, 8'b11_10_11_11, 1'b1, 2'b11, 2'b01, 1'b1}
   };

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(mode == 2'b00, "R1 mode", mode, 0);
      check(rd_data == 8'h00, "R1 rd", rd_data, 0);
      check(cpu_clk_en && per_clk_en, "R1 clk_en", {cpu_clk_en, per_clk_en}, 3);
      check(!wake && !take_irq, "R1 wake/take", {wake, take_irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VECS[k]) begin
         wr(VECS[k].wd);
         check(mode == VECS[k].xmode, "R2/R3/R4 mode", mode, VECS[k].xmode);
         check(rd_data == {VECS[k].xmode[1], VECS[k].xmode[0], 6'b0}, "R2/R3 rd", rd_data,
               {VECS[k].xmode[1], VECS[k].xmode[0], 6'b0});
         check(cpu_clk_en == 1'b0 && per_clk_en == (VECS[k].xmode != 2'b10),
               "R2/R3 clk_en", {cpu_clk_en, per_clk_en}, {1'b0, VECS[k].xmode != 2'b10});
         irq_req = VECS[k].req; irq_lvl = VECS[k].lvl;
         cpu_ie = VECS[k].ie; cpu_lvl = VECS[k].cl;
         @(negedge clk);
         check(wake == 1'b1 && mode == 2'b00 && rd_data == 8'h00, "R7 wake", {wake, mode}, 4);
         check(take_irq == VECS[k].xtake, "R8 take", take_irq, VECS[k].xtake);
         @(negedge clk);
         check(wake == 1'b0 && take_irq == 1'b0, "R7 pulse width", {wake, take_irq}, 0);
         irq_req = '0;
         @(negedge clk);
      end

      // R5 refusal with core interrupts disabled and enabled
      irq_req = 4'b0001; irq_lvl = 8'b11_11_11_01; cpu_ie = 1'b0; cpu_lvl = 2'b00;
      wr(8'h80);
      check(mode == 2'b00 && rd_data == 8'h00, "R5 refused ie0", mode, 0);
      cpu_ie = 1'b1; cpu_lvl = 2'b11;
      wr(8'h40);
      check(mode == 2'b00 && cpu_clk_en, "R5 refused ie1", mode, 0);
      irq_req = '0;
      // R5 entry allowed once request flag cleared
      wr(8'h40);
      check(mode == 2'b01, "R5 entry after clear", mode, 1);
      // R9 write during standby ignored
      wr(8'h80);
      check(mode == 2'b01 && rd_data == 8'h40, "R9 write in sleep", mode, 1);
      // R6 disabled-level source does not wake
      irq_req = 4'b0100; irq_lvl = 8'b11_11_11_11;
      repeat (3) @(negedge clk);
      check(mode == 2'b01 && !wake, "R6 no wake", {wake, mode}, 1);
      irq_req = 4'b0010; irq_lvl = 8'b11_11_00_11; cpu_ie = 1'b1; cpu_lvl = 2'b00;
      @(negedge clk);
      check(mode == 2'b00 && wake && !take_irq, "R8 equal level no take", {wake, take_irq}, 2);
      irq_req = 4'b1000; irq_lvl = 8'b11_11_11_11;
      wr(8'h80);
      check(mode == 2'b10, "R6 no block", mode, 2);
      irq_req = 4'b0001; irq_lvl = 8'b11_11_11_10; cpu_lvl = 2'b11;
      @(negedge clk);
      irq_req = '0;
      // R10 zero write keeps active
      wr(8'h00);
      check(mode == 2'b00 && rd_data == 8'h00, "R10 zero write", mode, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule